// File: doc/BRIEF.md
# Multi-Format Slave Audio Serial Transmitter

This block serialises stereo sample pairs onto a single data line for a receiver that owns the clocks. The bit clock and the left/right clock arrive as inputs. Both have already been brought into the block's system clock domain. The block detects bit-clock falling edges, changes its data output only there, and places each channel's word in one of three alignments: left-justified, I2S-style with a one-bit delay, or right-justified. In right-justified mode the block uses the length of the previous half-frame to place the last bit just before the next left/right edge.

Sample pairs enter through a valid/ready stream with a single holding slot. The rules for back-pressure are as follows:
- `pair_ready_o` depends only on internal state.
- A pair is taken only in a cycle where valid and ready are both high.
- A pair offered while ready is low is simply not taken, and valid does not have to persist.
- Ready stays low until the held pair moves into the transmit registers at the start of the next left half-frame.

Word length and alignment each come from a three-level select. Each select is given as a 2-bit code, and the block reads both codes at every half-frame boundary.

Top module: `audser_tx`

## Requirements
- R1: `sdata_o` is registered. It changes only in the clock cycle after a bit-clock fall is detected, which is a cycle where `bclk_i` is low and was high at the previous clock edge. In every other cycle it holds its value.
- R2: A half-frame starts at a bit-clock fall where `lrck_i` differs from its level at the previous fall. That fall is slot 0, and each later fall advances the slot by one. A level of 0 on `lrck_i` carries the left channel and a level of 1 carries the right channel.
- R3: For alignment code 01 (left-justified), the first bit of the word, its MSB, goes out in slot 0. The remaining bits follow MSB first, and every slot after the LSB outputs 0.
- R4: For alignment code 10 (I2S style), slot 0 outputs 0 and the MSB goes out in slot 1. Every slot after the LSB outputs 0. Bits that would fall beyond the end of the half-frame are dropped.
- R5: For alignment code 00 (right-justified), let P be the number of falls in the previous half-frame, counted from that half-frame's start or from reset, and let W be the word length. Slots 0 to P−W−1 output 0, then the W bits follow MSB first, so the LSB goes out in slot P−1.
- R6: In right-justified mode, when P is smaller than W, the whole half-frame outputs 0.
- R7: Word-length code 00 selects 16 bits, code 01 selects 20 bits, and codes 10 and 11 select 24 bits. Alignment code 11 behaves like code 10. The word sent is the top W bits of the SAMPLE_W-bit sample, and the lower bits are ignored.
- R8: Both select codes are read only at a half-frame start. A change in the middle of a half-frame has no effect until the next start.
- R9: `pair_ready_o` is high exactly when the holding slot is empty. After a transfer it drops in the next cycle. It rises again only after a left half-frame start has moved the held pair into the transmit registers.
- R10: Every left half-frame and the right half-frame after it send the pair that was held at that left start. If the slot was empty at that point, both channels send 0. Pairs offered while ready is low are ignored.
- R11: After reset, `sdata_o` is 0, `pair_ready_o` is 1, the transmit registers hold zeros, the last-seen left/right level is 1 (right), and the length counters are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Bit clock, already synchronous to clk |
| lrck_i | input | 1 | Left/right clock, 0 = left, 1 = right |
| fmt_sel_i | input | 2 | Alignment code: 00 right, 01 left, 10/11 I2S |
| wlen_sel_i | input | 2 | Word-length code: 00 = 16, 01 = 20, 10/11 = 24 |
| pair_valid_i | input | 1 | Sample pair offered |
| pair_ready_o | output | 1 | Holding slot empty |
| left_i | input | SAMPLE_W | Left sample, MSB-justified |
| right_i | input | SAMPLE_W | Right sample, MSB-justified |
| sdata_o | output | 1 | Serial data line |

## Verification
The assertions assume three things about the inputs:
- `lrck_i` changes only in a cycle where a bit-clock fall is seen.
- Each bit-clock phase lasts at least one system clock.
- The selects and `lrck_i` are steady during reset.

The stimulus always drives `bclk_i` low and the new left/right level at the same falling edge of the system clock. It keeps each bit-clock phase two system clocks long. It holds `lrck_i` at 1 through reset. Where a test needs a stall, it stretches a bit-clock phase rather than moving `lrck_i` between falls.

// File: rtl/audser_pkg.sv
package audser_pkg;

  // Alignment rule applied inside each half-frame
  typedef enum logic [1:0] {
    ALIGN_RIGHT = 2'd0,
    ALIGN_LEFT  = 2'd1,
    ALIGN_I2S   = 2'd2
  } align_e;

  // Three-level pin codes
  localparam logic [1:0] PIN_LO = 2'b00;
  localparam logic [1:0] PIN_HI = 2'b01;

  localparam int WL_SHORT = 16;
  localparam int WL_MID   = 20;
  localparam int WL_LONG  = 24;

  function automatic align_e align_from_pin(input logic [1:0] pin);
    case (pin)
      PIN_LO:  return ALIGN_RIGHT;
      PIN_HI:  return ALIGN_LEFT;
      default: return ALIGN_I2S;
    endcase
  endfunction

  function automatic logic [4:0] wlen_from_pin(input logic [1:0] pin);
    case (pin)
      PIN_LO:  return 5'(WL_SHORT);
      PIN_HI:  return 5'(WL_MID);
      default: return 5'(WL_LONG);
    endcase
  endfunction

endpackage

// File: rtl/audser_edge_track.sv
module audser_edge_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_i,
  input  logic             lrck_i,
  output logic             fall_o,
  output logic             bound_o,
  output logic             left_start_o,
  output logic [CNT_W-1:0] slot_o,
  output logic [CNT_W-1:0] plen_o
);

  localparam logic [CNT_W-1:0] LEN_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LEN_ONE = CNT_W'(1);

  logic             bclk_q;
  logic             lr_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] plen_q;

  assign fall_o       = bclk_q & ~bclk_i;
  assign bound_o      = fall_o & (lrck_i != lr_q);
  assign left_start_o = bound_o & ~lrck_i;
  assign slot_o       = bound_o ? '0 : len_q;
  assign plen_o       = bound_o ? len_q : plen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      lr_q   <= 1'b1;
      len_q  <= '0;
      plen_q <= '0;
    end else begin
      bclk_q <= bclk_i;
      if (fall_o) begin
        lr_q <= lrck_i;
        if (bound_o) begin
          plen_q <= len_q;
          len_q  <= LEN_ONE;
        end else if (len_q != LEN_MAX) begin
          len_q <= len_q + LEN_ONE;
        end
      end
    end
  end

  // Input assumption: the left/right level moves only together with a bit-clock fall
  AST_LR_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_o |-> $stable(lrck_i)); // R2

  AST_LEN_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> (len_q != '0)); // R5

endmodule

// File: rtl/audser_pair_buf.sv
module audser_pair_buf #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                left_start_i,
  input  logic                valid_i,
  output logic                ready_o,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic [SAMPLE_W-1:0] cur_l_o,
  output logic [SAMPLE_W-1:0] act_r_o
);

  logic                full_q;
  logic                take;
  logic [SAMPLE_W-1:0] hold_l;
  logic [SAMPLE_W-1:0] hold_r;
  logic [SAMPLE_W-1:0] act_l;
  logic [SAMPLE_W-1:0] act_r;

  assign ready_o = ~full_q;
  assign take    = valid_i & ~full_q;
  assign cur_l_o = left_start_i ? (full_q ? hold_l : '0) : act_l;
  assign act_r_o = act_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_l <= '0;
      hold_r <= '0;
      act_l  <= '0;
      act_r  <= '0;
    end else begin
      if (left_start_i) begin
        act_l <= full_q ? hold_l : '0;
        act_r <= full_q ? hold_r : '0;
      end
      if (take) begin
        hold_l <= left_i;
        hold_r <= right_i;
        full_q <= 1'b1;
      end else if (left_start_i) begin
        full_q <= 1'b0;
      end
    end
  end

  AST_TAKE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ready_o) |=> !ready_o); // R9

  AST_READY_AT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(left_start_i)); // R9

  AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (left_start_i && ready_o) |=> (act_l == '0 && act_r == '0)); // R10

endmodule

// File: rtl/audser_bit_pick.sv
module audser_bit_pick
  import audser_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 8
) (
  input  align_e                fmt_i,
  input  logic [CNT_W:0]        wlen_i,
  input  logic [CNT_W-1:0]      slot_i,
  input  logic [CNT_W-1:0]      plen_i,
  input  logic [SAMPLE_W-1:0]   word_i,
  output logic                  bit_o
);

  localparam int IDX_W = CNT_W + 1;

  logic [IDX_W-1:0]    slot_x;
  logic [IDX_W-1:0]    plen_x;
  logic [IDX_W-1:0]    start;
  logic [IDX_W-1:0]    k;
  logic                in_range;
  logic [SAMPLE_W-1:0] shifted;

  assign slot_x = {1'b0, slot_i};
  assign plen_x = {1'b0, plen_i};

  always_comb begin
    in_range = 1'b1;
    start    = '0;
    case (fmt_i)
      ALIGN_LEFT: start = '0;
      ALIGN_I2S:  start = IDX_W'(1);
      default: begin
        if (plen_x >= wlen_i) start = plen_x - wlen_i;
        else                  in_range = 1'b0;
      end
    endcase
    if (slot_x < start) in_range = 1'b0;
    k = slot_x - start;
    if (k >= wlen_i) in_range = 1'b0;
    shifted = word_i << k;
    bit_o   = in_range & shifted[SAMPLE_W-1];
  end

endmodule

// File: rtl/audser_tx.sv
module audser_tx
  import audser_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_i,
  input  logic                lrck_i,
  input  logic [1:0]          fmt_sel_i,
  input  logic [1:0]          wlen_sel_i,
  input  logic                pair_valid_i,
  output logic                pair_ready_o,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                sdata_o
);

  localparam int IDX_W = CNT_W + 1;

  logic                fall;
  logic                bound;
  logic                left_start;
  logic [CNT_W-1:0]    slot;
  logic [CNT_W-1:0]    plen;
  logic [SAMPLE_W-1:0] cur_l;
  logic [SAMPLE_W-1:0] act_r;
  logic [SAMPLE_W-1:0] word_eff;
  align_e              fmt_q;
  align_e              fmt_eff;
  logic [IDX_W-1:0]    wl_q;
  logic [IDX_W-1:0]    wl_eff;
  logic                next_bit;

  audser_edge_track #(.CNT_W(CNT_W)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .bclk_i       (bclk_i),
    .lrck_i       (lrck_i),
    .fall_o       (fall),
    .bound_o      (bound),
    .left_start_o (left_start),
    .slot_o       (slot),
    .plen_o       (plen)
  );

  audser_pair_buf #(.SAMPLE_W(SAMPLE_W)) u_buf (
    .clk          (clk),
    .rst_n        (rst_n),
    .left_start_i (left_start),
    .valid_i      (pair_valid_i),
    .ready_o      (pair_ready_o),
    .left_i       (left_i),
    .right_i      (right_i),
    .cur_l_o      (cur_l),
    .act_r_o      (act_r)
  );

  // Selects take effect at a half-frame start and hold for the rest of it
  always_comb begin
    fmt_eff  = bound ? align_from_pin(fmt_sel_i) : fmt_q;
    wl_eff   = bound ? IDX_W'(wlen_from_pin(wlen_sel_i)) : wl_q;
    word_eff = lrck_i ? act_r : cur_l;
  end

  audser_bit_pick #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_pick (
    .fmt_i  (fmt_eff),
    .wlen_i (wl_eff),
    .slot_i (slot),
    .plen_i (plen),
    .word_i (word_eff),
    .bit_o  (next_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q   <= ALIGN_LEFT;
      wl_q    <= IDX_W'(WL_LONG);
      sdata_o <= 1'b0;
    end else begin
      if (bound) begin
        fmt_q <= fmt_eff;
        wl_q  <= wl_eff;
      end
      if (fall) sdata_o <= next_bit;
    end
  end

  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdata_o)); // R1

  AST_I2S_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && fmt_eff == ALIGN_I2S && slot == '0) |=> !sdata_o); // R4

  AST_RJ_SHORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && fmt_eff == ALIGN_RIGHT && {1'b0, plen} < wl_eff) |=> !sdata_o); // R6

endmodule

// File: tb/test_audser_tx.sv
module test_audser_tx;
  localparam int SW = 24;
  localparam int CW = 8;
  localparam int LEN_SAT = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bclk = 1'b0;
  logic          lrck = 1'b1;
  logic [1:0]    fmt_sel = 2'b01;
  logic [1:0]    wl_sel = 2'b10;
  logic          pv = 1'b0;
  logic [SW-1:0] pl = '0;
  logic [SW-1:0] pr = '0;
  logic          pready;
  logic          sdata;

  always #2 clk = ~clk;

  audser_tx #(.SAMPLE_W(SW), .CNT_W(CW)) i_audser_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .bclk_i       (bclk),
    .lrck_i       (lrck),
    .fmt_sel_i    (fmt_sel),
    .wlen_sel_i   (wl_sel),
    .pair_valid_i (pv),
    .pair_ready_o (pready),
    .left_i       (pl),
    .right_i      (pr),
    .sdata_o      (sdata)
  );

  int    n_chk = 0;
  int    n_err = 0;
  int    cyc = 0;
  bit    run_cmp = 0;
  string cur_req = "R11";

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: a bit queue built at each half-frame start
  bit          m_bprev;
  bit          m_lr;
  int          m_len;
  int          m_plen;
  bit          m_full;
  logic [SW-1:0] m_hl, m_hr, m_al, m_ar;
  bit          m_sd;
  bit          m_q[$];

  always @(posedge clk) begin
    bit            acc;
    logic [SW-1:0] w;
    int            wl;
    if (!rst_n) begin
      m_bprev = 0; m_lr = 1; m_len = 0; m_plen = 0; m_full = 0;
      m_hl = '0; m_hr = '0; m_al = '0; m_ar = '0; m_sd = 0;
      m_q.delete();
    end else begin
      acc = pv && !m_full;
      if (m_bprev && !bclk) begin
        if (lrck != m_lr) begin
          m_plen = m_len;
          m_len  = 1;
          if (!lrck) begin
            if (m_full) begin m_al = m_hl; m_ar = m_hr; m_full = 0; end
            else begin m_al = '0; m_ar = '0; end
          end
          w  = lrck ? m_ar : m_al;
          wl = (wl_sel == 2'b00) ? 16 : (wl_sel == 2'b01) ? 20 : 24;
          m_q.delete();
          if (fmt_sel == 2'b00) begin
            if (m_plen >= wl) repeat (m_plen - wl) m_q.push_back(1'b0);
            else wl = 0;
          end else if (fmt_sel != 2'b01) begin
            m_q.push_back(1'b0);
          end
          for (int i = 0; i < wl; i++) m_q.push_back(w[SW-1-i]);
        end else if (m_len < LEN_SAT) begin
          m_len++;
        end
        m_lr = lrck;
        m_sd = (m_q.size() > 0) ? m_q.pop_front() : 1'b0;
      end
      if (acc) begin m_hl = pl; m_hr = pr; m_full = 1; end
      m_bprev = bclk;
    end
  end

  always @(negedge clk) begin
    if (run_cmp) begin
      chk(sdata === m_sd, cur_req, "sdata", longint'(sdata), longint'(m_sd));
      chk(pready === !m_full, cur_req, "ready", longint'(pready), longint'(!m_full));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic bit_clk(input bit lr);
    @(negedge clk); bclk = 1'b0; lrck = lr;
    @(negedge clk);
    @(negedge clk); bclk = 1'b1;
    @(negedge clk);
  endtask

  task automatic half(input int n, input bit lr);
    repeat (n) bit_clk(lr);
  endtask

  task automatic frame(input int n);
    half(n, 1'b0);
    half(n, 1'b1);
  endtask

  task automatic send(input logic [SW-1:0] l, input logic [SW-1:0] r);
    @(negedge clk);
    while (!pready) @(negedge clk);
    pl = l; pr = r; pv = 1'b1;
    @(negedge clk);
    pv = 1'b0;
    chk(pready === 1'b0, "R9", "ready after transfer", longint'(pready), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(sdata === 1'b0, "R11", "sdata after reset", longint'(sdata), 0);
    chk(pready === 1'b1, "R11", "ready after reset", longint'(pready), 1);
    run_cmp = 1;

    cur_req = "R2";
    half(32, 1'b1);

    cur_req = "R3";
    fmt_sel = 2'b01; wl_sel = 2'b10;
    send(24'hA5C3_96, 24'h3C_F00F);
    frame(32);
    chk(pready === 1'b1, "R9", "ready after left start", longint'(pready), 1);

    cur_req = "R10";
    frame(32);

    cur_req = "R7";
    wl_sel = 2'b00;
    send(24'hF0F0_FF, 24'h81_8181);
    frame(32);
    wl_sel = 2'b01;
    send(24'h12_3456, 24'hED_CBA9);
    frame(32);

    cur_req = "R4";
    fmt_sel = 2'b10; wl_sel = 2'b10;
    send(24'hC0_0003, 24'h80_0001);
    frame(32);
    send(24'hFF_FFFF, 24'hAA_AAAB);
    frame(24);
    fmt_sel = 2'b11; wl_sel = 2'b11;
    send(24'h5A_5A5A, 24'h69_9696);
    frame(30);

    cur_req = "R5";
    fmt_sel = 2'b00; wl_sel = 2'b01;
    send(24'h9B_ADF1, 24'h70_0F0E);
    frame(32);
    send(24'hE1_2345, 24'h1F_EDCB);
    frame(32);

    cur_req = "R6";
    wl_sel = 2'b10;
    send(24'hFF_FFFF, 24'hFF_FFFF);
    frame(16);
    send(24'hFF_FFFF, 24'hFF_FFFF);
    frame(16);

    cur_req = "R8";
    fmt_sel = 2'b01; wl_sel = 2'b10;
    send(24'hB7_1E3D, 24'h4C_A5F2);
    half(8, 1'b0);
    fmt_sel = 2'b10; wl_sel = 2'b00;
    half(24, 1'b0);
    half(32, 1'b1);

    cur_req = "R10";
    send(24'h33_CC33, 24'hCC_33CC);
    pl = 24'hFF_FFFF; pr = 24'hFF_FFFF; pv = 1'b1;
    repeat (6) @(negedge clk);
    chk(pready === 1'b0, "R10", "ready while held", longint'(pready), 0);
    pv = 1'b0;
    frame(32);

    cur_req = "R1";
    fmt_sel = 2'b01;
    send(24'hDE_ADBE, 24'h0B_EEF1);
    half(5, 1'b0);
    begin
      logic held;
      held = sdata;
      repeat (20) @(negedge clk);
      chk(sdata === held, "R1", "sdata during stall", longint'(sdata), longint'(held));
    end
    half(27, 1'b0);
    half(32, 1'b1);

    run_cmp = 0;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule